// File: doc/BRIEF.md
# Floppy Controller Register File and Positioning Engine

This block is the host-side face of a single-density floppy controller that serves up to four drives. A host reaches five registers through a 3-bit port offset: command/status, track, sector, data and an extended drive-select register. Writes take effect on the clock edge. Reads are combinational and have no side effects. Each drive keeps its own track, sector, step-direction, error, busy and interrupt state, and it has its own head-load timer. Every access goes to the drive that is currently selected.

The block runs the positioning commands itself, and each one completes in a single cycle: restore, seek, step, step in and step out. The upper nibble of the byte written to offset 0 is the command code. Data-transfer commands are not executed here. The block passes them to a separate transfer engine by way of a start strobe, an abort strobe and the command code. The engine reports that a transfer has finished by pulsing a done input, and that pulse completes the command on the drive that started it.

Top module: `fdc_regfile`

## Requirements
- R1: Offset 1 holds the track, offset 2 the sector and offset 3 the data byte, and each reads back what was last written to it. Offsets 5 to 7 read 0xFF, and writes to them change nothing.
- R2: Synchronous active-low reset does the following. Every drive gets track 0, sector 1, step direction inward, and busy, error, interrupt and head cleared. Drive 0 is selected and the data register is 0.
- R3: Command code 0x0 (restore) sets the track to 0 and clears the seek-error bit.
- R4: Command code 0x1 (seek) loads the track from the data register when that value is below 77. Otherwise it sets status bit 4 and leaves the track unchanged.
- R5: Codes 0x4/0x5 step inward and set the drive's remembered direction to inward. Codes 0x6/0x7 step outward and set it to outward. Codes 0x2/0x3 step in the remembered direction. The track changes only when code bit 0 is 1. Stepping outward at track 0, or inward at track 76 or above, sets seek error and leaves the track unchanged. A legal step clears seek error.
- R6: In the cycle after any positioning command (codes 0x0-0x7), busy is 0 and the drive's interrupt is pending.
- R7: The status word at offset 0 is laid out as follows: bit 7 drive not ready, bit 6 write protected, bit 5 head loaded, bit 4 seek error, bit 3 zero, bit 2 track is 0, bit 1 index (equal to drive ready), bit 0 busy.
- R8: A positioning command with command bit 3 set loads the head, and so does any data command. The head unloads HEAD_MS x CLK_PER_MS cycles after the most recent load. A new load restarts that interval.
- R9: A write to offset 4 selects drive ~data[5:4]. Reading offset 4 returns 0x00 while the selected drive's interrupt is pending and 0x80 otherwise.
- R10: A command with bit 7 set, other than code 0xD, does several things. It pulses xfer_start and xfer_abort for one cycle and presents its code on xfer_cmd. It sets busy and clears the interrupt and the seek error. xfer_done later clears busy and sets the interrupt on the drive that started the transfer.
- R11: Code 0xD (force interrupt) pulses xfer_abort without xfer_start and clears both busy and interrupt.
- R12: Track, sector, direction, error, busy, interrupt and head state are held separately for each drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_addr | input | 3 | Port offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| drv_ready | input | NUM_DRIVES | Drive ready, one bit per drive |
| drv_wprot | input | NUM_DRIVES | Media write-protected, one bit per drive |
| xfer_done | input | 1 | Transfer engine finished the started command |
| xfer_start | output | 1 | One-cycle start of a data command |
| xfer_abort | output | 1 | One-cycle cancel of any running transfer |
| xfer_cmd | output | 4 | Code of the started data command |
| drv_sel | output | log2(NUM_DRIVES) | Currently selected drive |
| irq | output | 1 | Interrupt pending on the selected drive |

## Verification
The assertions assume that each bus_wr is a single-cycle strobe. They also assume that xfer_done arrives only while a transfer started here is outstanding, and that the engine never pulses it after an abort. The bench meets these conditions. It issues one register access per cycle with idle cycles between commands, and it raises xfer_done only after a data command has been accepted and has not been forced off. The ready and write-protect inputs stay fixed during the run, so every status comparison depends only on state held in the block.

// File: rtl/fdc_pkg.sv
`timescale 1ns/1ps
// Shared constants for the floppy controller register file.
// Assumes a 3-bit port offset and commands carried in the upper nibble.
package fdc_pkg;
    localparam logic [2:0] PORT_CMD  = 3'd0;
    localparam logic [2:0] PORT_TRK  = 3'd1;
    localparam logic [2:0] PORT_SEC  = 3'd2;
    localparam logic [2:0] PORT_DATA = 3'd3;
    localparam logic [2:0] PORT_EXT  = 3'd4;

    localparam logic [3:0] CMD_FORCE = 4'hD;

    // Kind of head motion selected by command bits [2:1].
    typedef enum logic [1:0] {
        MV_ABS  = 2'd0,
        MV_STEP = 2'd1,
        MV_IN   = 2'd2,
        MV_OUT  = 2'd3
    } motion_e;
endpackage

// File: rtl/fdc_pos_engine.sv
`timescale 1ns/1ps
// Positioning arithmetic: given a command's low three code bits and the
// current drive state, produce the next track, direction and error bit.
// Purely combinational; the caller applies results only for positioning codes.
module fdc_pos_engine #(
    parameter int TRACKS = 77
) (
    input  logic [2:0] code,
    input  logic [7:0] trk_cur,
    input  logic [7:0] data_in,
    input  logic       dir_in_cur,
    output logic [7:0] trk_nxt,
    output logic       dir_nxt,
    output logic       err_nxt
);
    import fdc_pkg::*;

    localparam logic [7:0] TRK_LIM  = 8'(TRACKS);
    localparam logic [7:0] TRK_LAST = 8'(TRACKS - 1);

    motion_e motion;
    logic    upd;
    logic    inward;
    logic    legal;

    assign motion = motion_e'(code[2:1]);
    assign upd    = code[0];

    // Resolve direction, legality and resulting track for the command.
    always_comb begin
        trk_nxt = trk_cur;
        dir_nxt = dir_in_cur;
        err_nxt = 1'b0;
        inward  = 1'b0;
        legal   = 1'b0;
        if (motion == MV_ABS) begin
            if (!upd) begin
                trk_nxt = 8'd0;
            end else if (data_in < TRK_LIM) begin
                trk_nxt = data_in;
            end else begin
                err_nxt = 1'b1;
            end
        end else begin
            inward = (motion == MV_IN) || ((motion == MV_STEP) && dir_in_cur);
            if (motion != MV_STEP) begin
                dir_nxt = inward;
            end
            legal = inward ? (trk_cur < TRK_LAST) : (trk_cur != 8'd0);
            if (!legal) begin
                err_nxt = 1'b1;
            end else if (upd) begin
                trk_nxt = inward ? trk_cur + 8'd1 : trk_cur - 8'd1;
            end
        end
    end
endmodule

// File: rtl/fdc_head_timer.sv
`timescale 1ns/1ps
// Head-load timer for one drive: a load pulse raises the head and starts a
// countdown; the head drops when CYCLES edges pass without another load.
// Assumes CYCLES >= 1.
module fdc_head_timer #(
    parameter int CYCLES = 5_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic loaded
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt;

    // Reload on activity, otherwise count down and unload at expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            loaded <= 1'b0;
        end else if (load) begin
            cnt    <= CW'(CYCLES);
            loaded <= 1'b1;
        end else if (cnt != '0) begin
            cnt <= cnt - CW'(1);
            if (cnt == CW'(1)) begin
                loaded <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/fdc_drive_regs.sv
`timescale 1ns/1ps
// Register slice for one drive: track, sector, direction, seek error, busy,
// interrupt and head state. Assumes 'hit' is high only for a bus write while
// this drive is selected, and that pos_* already reflect this drive's state.
module fdc_drive_regs #(
    parameter int HEAD_CYC = 5_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hit,
    input  logic [2:0] addr,
    input  logic [7:0] wdata,
    input  logic [7:0] pos_trk,
    input  logic       pos_dir,
    input  logic       pos_err,
    input  logic       done_hit,
    output logic [7:0] trk,
    output logic [7:0] sec,
    output logic       dir_in,
    output logic       err,
    output logic       busy,
    output logic       irq,
    output logic       head
);
    import fdc_pkg::*;

    logic cmd_hit;
    logic is_pos;
    logic is_force;
    logic is_data;
    logic head_ld;

    assign cmd_hit  = hit && (addr == PORT_CMD);
    assign is_pos   = !wdata[7];
    assign is_force = (wdata[7:4] == CMD_FORCE);
    assign is_data  = wdata[7] && !is_force;
    assign head_ld  = cmd_hit && (is_data || (is_pos && wdata[3]));

    // Per-drive register updates; a command write overrides a done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk    <= 8'd0;
            sec    <= 8'd1;
            dir_in <= 1'b1;
            err    <= 1'b0;
            busy   <= 1'b0;
            irq    <= 1'b0;
        end else begin
            if (done_hit) begin
                busy <= 1'b0;
                irq  <= 1'b1;
            end
            if (hit) begin
                case (addr)
                    PORT_CMD: begin
                        if (is_pos) begin
                            trk    <= pos_trk;
                            dir_in <= pos_dir;
                            err    <= pos_err;
                            busy   <= 1'b0;
                            irq    <= 1'b1;
                        end else if (is_force) begin
                            busy <= 1'b0;
                            irq  <= 1'b0;
                        end else begin
                            busy <= 1'b1;
                            irq  <= 1'b0;
                            err  <= 1'b0;
                        end
                    end
                    PORT_TRK: trk <= wdata;
                    PORT_SEC: sec <= wdata;
                    default: ;
                endcase
            end
        end
    end

    fdc_head_timer #(.CYCLES(HEAD_CYC)) i_head (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (head_ld),
        .loaded (head)
    );
endmodule

// File: rtl/fdc_regfile.sv
`timescale 1ns/1ps
// Host register file and positioning engine of a multi-drive floppy
// controller. Decodes port offsets, runs positioning commands in one cycle,
// hands data commands to an external transfer engine, selects the drive and
// assembles the status word. Assumes single-cycle bus_wr strobes.
module fdc_regfile #(
    parameter int NUM_DRIVES = 4,
    parameter int TRACKS     = 77,
    parameter int CLK_PER_MS = 50_000,
    parameter int HEAD_MS    = 100,
    localparam int SEL_W     = $clog2(NUM_DRIVES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic [2:0]            bus_addr,
    input  logic [7:0]            bus_wdata,
    output logic [7:0]            bus_rdata,
    input  logic [NUM_DRIVES-1:0] drv_ready,
    input  logic [NUM_DRIVES-1:0] drv_wprot,
    input  logic                  xfer_done,
    output logic                  xfer_start,
    output logic                  xfer_abort,
    output logic [3:0]            xfer_cmd,
    output logic [SEL_W-1:0]      drv_sel,
    output logic                  irq
);
    import fdc_pkg::*;

    localparam int HEAD_CYC = CLK_PER_MS * HEAD_MS;

    logic [SEL_W-1:0]            sel_q;
    logic [SEL_W-1:0]            xdrv_q;
    logic [SEL_W-1:0]            sel_cand;
    logic [7:0]                  data_q;
    logic [NUM_DRIVES-1:0][7:0]  trk_v;
    logic [NUM_DRIVES-1:0][7:0]  sec_v;
    logic [NUM_DRIVES-1:0]       dir_v;
    logic [NUM_DRIVES-1:0]       err_v;
    logic [NUM_DRIVES-1:0]       busy_v;
    logic [NUM_DRIVES-1:0]       irq_v;
    logic [NUM_DRIVES-1:0]       head_v;
    logic [7:0]                  pos_trk;
    logic                        pos_dir;
    logic                        pos_err;
    logic [7:0]                  trk_sel;
    logic [7:0]                  stat_sel;
    logic                        cmd_wr;

    assign cmd_wr   = bus_wr && (bus_addr == PORT_CMD);
    assign trk_sel  = trk_v[sel_q];
    assign sel_cand = ~bus_wdata[4 +: SEL_W];

    fdc_pos_engine #(.TRACKS(TRACKS)) i_pos (
        .code       (bus_wdata[6:4]),
        .trk_cur    (trk_sel),
        .data_in    (data_q),
        .dir_in_cur (dir_v[sel_q]),
        .trk_nxt    (pos_trk),
        .dir_nxt    (pos_dir),
        .err_nxt    (pos_err)
    );

    for (genvar g = 0; g < NUM_DRIVES; g++) begin : g_drive
        fdc_drive_regs #(.HEAD_CYC(HEAD_CYC)) i_regs (
            .clk      (clk),
            .rst_n    (rst_n),
            .hit      (bus_wr && (sel_q == SEL_W'(g))),
            .addr     (bus_addr),
            .wdata    (bus_wdata),
            .pos_trk  (pos_trk),
            .pos_dir  (pos_dir),
            .pos_err  (pos_err),
            .done_hit (xfer_done && (xdrv_q == SEL_W'(g))),
            .trk      (trk_v[g]),
            .sec      (sec_v[g]),
            .dir_in   (dir_v[g]),
            .err      (err_v[g]),
            .busy     (busy_v[g]),
            .irq      (irq_v[g]),
            .head     (head_v[g])
        );
    end

    // Drive selection and data register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= '0;
            data_q <= 8'd0;
        end else if (bus_wr) begin
            if (bus_addr == PORT_DATA) begin
                data_q <= bus_wdata;
            end
            if ((bus_addr == PORT_EXT) &&
                ({1'b0, sel_cand} < (SEL_W + 1)'(NUM_DRIVES))) begin
                sel_q <= sel_cand;
            end
        end
    end

    // Hand-off strobes toward the transfer engine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xfer_start <= 1'b0;
            xfer_abort <= 1'b0;
            xfer_cmd   <= 4'd0;
            xdrv_q     <= '0;
        end else begin
            xfer_start <= 1'b0;
            xfer_abort <= 1'b0;
            if (cmd_wr && bus_wdata[7]) begin
                xfer_abort <= 1'b1;
                if (bus_wdata[7:4] != CMD_FORCE) begin
                    xfer_start <= 1'b1;
                    xfer_cmd   <= bus_wdata[7:4];
                    xdrv_q     <= sel_q;
                end
            end
        end
    end

    // Status word of the selected drive.
    always_comb begin
        stat_sel = {~drv_ready[sel_q], drv_wprot[sel_q], head_v[sel_q],
                    err_v[sel_q], 1'b0, (trk_sel == 8'd0),
                    drv_ready[sel_q], busy_v[sel_q]};
    end

    // Read multiplexer over the port offsets.
    always_comb begin
        case (bus_addr)
            PORT_CMD:  bus_rdata = stat_sel;
            PORT_TRK:  bus_rdata = trk_sel;
            PORT_SEC:  bus_rdata = sec_v[sel_q];
            PORT_DATA: bus_rdata = data_q;
            PORT_EXT:  bus_rdata = irq_v[sel_q] ? 8'h00 : 8'h80;
            default:   bus_rdata = 8'hFF;
        endcase
    end

    assign drv_sel = sel_q;
    assign irq     = irq_v[sel_q];
endmodule

// File: rtl/fdc_regfile_chk.sv
`timescale 1ns/1ps
// Assertion checker for fdc_regfile, attached with the bind below.
// Assumes single-cycle bus_wr strobes and well-behaved xfer_done.
module fdc_regfile_chk #(
    parameter int TRACKS = 77
) (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_wr,
    input logic [2:0] bus_addr,
    input logic [3:0] cmd_nib,
    input logic       irq,
    input logic       xfer_start,
    input logic       xfer_abort,
    input logic       st_busy,
    input logic       st_trk0,
    input logic       st_err,
    input logic [7:0] trk_sel,
    input logic [7:0] data_q
);
    logic cmd_wr;
    assign cmd_wr = bus_wr && (bus_addr == 3'd0);

    a_r6_pos_completes: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !cmd_nib[3]) |=> (irq && !st_busy));

    a_r3_restore_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_nib == 4'h0) |=> (trk_sel == 8'd0 && st_trk0 && !st_err));

    a_r4_seek_range: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_nib == 4'h1 && data_q >= 8'(TRACKS)) |=> ($stable(trk_sel) && st_err));

    a_r10_start_has_abort: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |-> xfer_abort);

    a_r10_irq_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_nib[3]) |=> !irq);

    a_r11_force_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_nib == 4'hD) |=> (xfer_abort && !xfer_start && !st_busy));
endmodule

bind fdc_regfile fdc_regfile_chk #(.TRACKS(TRACKS)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .cmd_nib    (bus_wdata[7:4]),
    .irq        (irq),
    .xfer_start (xfer_start),
    .xfer_abort (xfer_abort),
    .st_busy    (stat_sel[0]),
    .st_trk0    (stat_sel[2]),
    .st_err     (stat_sel[4]),
    .trk_sel    (trk_sel),
    .data_q     (data_q)
);

// File: tb/test_fdc_regfile.sv
`timescale 1ns/1ps
// Bench: behavioural reference model updated on each rising edge and compared
// with every output on each falling edge, plus directed value checks.
module test_fdc_regfile;
    localparam int LIMIT = 30;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic [3:0] drv_ready = 4'b1011;
    logic [3:0] drv_wprot = 4'b0010;
    logic       xfer_done = 1'b0;
    logic       xfer_start;
    logic       xfer_abort;
    logic [3:0] xfer_cmd;
    logic [1:0] drv_sel;
    logic       irq;

    fdc_regfile #(.NUM_DRIVES(4), .TRACKS(77), .CLK_PER_MS(3), .HEAD_MS(10)) i_fdc_regfile (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .drv_ready(drv_ready),
        .drv_wprot(drv_wprot), .xfer_done(xfer_done), .xfer_start(xfer_start),
        .xfer_abort(xfer_abort), .xfer_cmd(xfer_cmd), .drv_sel(drv_sel), .irq(irq)
    );

    always #10 clk = ~clk;

    int    n_checks = 0;
    int    n_err = 0;
    bit    finished = 0;
    string cur_req = "R2";

    // Reference model state.
    int m_trk [4], m_sec [4], m_dir [4], m_err [4], m_busy [4], m_irq [4], m_head [4], m_hcnt [4];
    int m_data, m_sel, m_xdrv, m_xc, m_xs, m_xa, code, mv;
    bit ld [4];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int d = 0; d < 4; d++) begin
                m_trk[d] = 0; m_sec[d] = 1; m_dir[d] = 1; m_err[d] = 0;
                m_busy[d] = 0; m_irq[d] = 0; m_head[d] = 0; m_hcnt[d] = 0;
            end
            m_data = 0; m_sel = 0; m_xdrv = 0; m_xc = 0; m_xs = 0; m_xa = 0;
        end else begin
            code = int'(bus_wdata) / 16;
            for (int d = 0; d < 4; d++)
                ld[d] = bus_wr && bus_addr == 0 && m_sel == d &&
                        ((code < 8 && bus_wdata[3]) || (code >= 8 && code != 13));
            for (int d = 0; d < 4; d++) begin
                if (ld[d]) begin m_head[d] = 1; m_hcnt[d] = LIMIT; end
                else if (m_hcnt[d] > 0) begin
                    m_hcnt[d]--;
                    if (m_hcnt[d] == 0) m_head[d] = 0;
                end
            end
            m_xs = 0; m_xa = 0;
            if (xfer_done) begin m_busy[m_xdrv] = 0; m_irq[m_xdrv] = 1; end
            if (bus_wr) begin
                case (bus_addr)
                    3'd0: begin
                        if (code < 8) begin
                            if (code == 0) begin m_trk[m_sel] = 0; m_err[m_sel] = 0; end
                            else if (code == 1) begin
                                if (m_data < 77) begin m_trk[m_sel] = m_data; m_err[m_sel] = 0; end
                                else m_err[m_sel] = 1;
                            end else begin
                                if (code < 4) mv = m_dir[m_sel];
                                else if (code < 6) mv = 1;
                                else mv = -1;
                                if (code >= 4) m_dir[m_sel] = mv;
                                if ((mv > 0 && m_trk[m_sel] < 76) || (mv < 0 && m_trk[m_sel] > 0)) begin
                                    m_err[m_sel] = 0;
                                    if (code % 2 == 1) m_trk[m_sel] += mv;
                                end else m_err[m_sel] = 1;
                            end
                            m_busy[m_sel] = 0; m_irq[m_sel] = 1;
                        end else if (code == 13) begin
                            m_busy[m_sel] = 0; m_irq[m_sel] = 0; m_xa = 1;
                        end else begin
                            m_busy[m_sel] = 1; m_irq[m_sel] = 0; m_err[m_sel] = 0;
                            m_xa = 1; m_xs = 1; m_xc = code; m_xdrv = m_sel;
                        end
                    end
                    3'd1: m_trk[m_sel] = int'(bus_wdata);
                    3'd2: m_sec[m_sel] = int'(bus_wdata);
                    3'd3: m_data = int'(bus_wdata);
                    3'd4: m_sel = 3 - (int'(bus_wdata) / 16) % 4;
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [7:0] m_rdata(input logic [2:0] a);
        case (a)
            3'd0: return {~drv_ready[m_sel], drv_wprot[m_sel], 1'(m_head[m_sel]), 1'(m_err[m_sel]),
                          1'b0, (m_trk[m_sel] == 0), drv_ready[m_sel], 1'(m_busy[m_sel])};
            3'd1: return 8'(m_trk[m_sel]);
            3'd2: return 8'(m_sec[m_sel]);
            3'd3: return 8'(m_data);
            3'd4: return (m_irq[m_sel] != 0) ? 8'h00 : 8'h80;
            default: return 8'hFF;
        endcase
    endfunction

    task automatic fail(input string what, input int got, input int exp);
        n_err++;
        $display("FAIL %s %s got=%0h exp=%0h", cur_req, what, got, exp);
    endtask

    task automatic compare();
        n_checks++;
        if (bus_rdata !== m_rdata(bus_addr)) fail("rdata", int'(bus_rdata), int'(m_rdata(bus_addr)));
        if (irq !== 1'(m_irq[m_sel])) fail("irq", int'(irq), m_irq[m_sel]);
        if (drv_sel !== 2'(m_sel)) fail("drv_sel", int'(drv_sel), m_sel);
        if (xfer_start !== 1'(m_xs)) fail("xfer_start", int'(xfer_start), m_xs);
        if (xfer_abort !== 1'(m_xa)) fail("xfer_abort", int'(xfer_abort), m_xa);
        if (m_xs != 0 && xfer_cmd !== 4'(m_xc)) fail("xfer_cmd", int'(xfer_cmd), m_xc);
    endtask

    task automatic cyc(input logic wr, input logic [2:0] a, input logic [7:0] d, input logic done);
        bus_wr = wr; bus_addr = a; bus_wdata = d; xfer_done = done;
        @(negedge clk);
        compare();
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        cyc(1'b1, a, d, 1'b0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 3'd0, 8'd0, 1'b0);
    endtask

    task automatic chk(input string tag, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_err++;
            $display("FAIL %s directed got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic peek(input logic [2:0] a, input logic [7:0] exp);
        cyc(1'b0, a, 8'd0, 1'b0);
        chk(cur_req, int'(bus_rdata), int'(exp));
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        // R2: reset state
        cur_req = "R2";
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        peek(3'd0, 8'h06); peek(3'd1, 8'h00); peek(3'd2, 8'h01); peek(3'd4, 8'h80);
        chk("R2", int'(drv_sel), 0);

        // R1: plain registers and unused offsets
        cur_req = "R1";
        wr(3'd1, 8'h2A); wr(3'd2, 8'h07); wr(3'd3, 8'h33);
        peek(3'd1, 8'h2A); peek(3'd2, 8'h07); peek(3'd3, 8'h33);
        wr(3'd5, 8'h55); wr(3'd6, 8'hAA); wr(3'd7, 8'h01);
        peek(3'd5, 8'hFF); peek(3'd7, 8'hFF);
        peek(3'd1, 8'h2A); peek(3'd2, 8'h07); peek(3'd3, 8'h33);

        // R4 and R6: seek in range, out of range, last legal track
        cur_req = "R4";
        wr(3'd3, 8'd40); wr(3'd0, 8'h10);
        peek(3'd1, 8'd40); peek(3'd0, 8'h02);
        cur_req = "R6";
        peek(3'd4, 8'h00);
        cur_req = "R4";
        wr(3'd3, 8'd77); wr(3'd0, 8'h10);
        peek(3'd1, 8'd40); peek(3'd0, 8'h12);
        wr(3'd3, 8'd76); wr(3'd0, 8'h10);
        peek(3'd1, 8'd76); peek(3'd0, 8'h02);

        // R3: restore
        cur_req = "R3";
        wr(3'd0, 8'h00);
        peek(3'd1, 8'd0); peek(3'd0, 8'h06);

        // R5: stepping and remembered direction
        cur_req = "R5";
        wr(3'd0, 8'h50); wr(3'd0, 8'h50); peek(3'd1, 8'd2);
        wr(3'd0, 8'h30); peek(3'd1, 8'd3);
        wr(3'd0, 8'h70); peek(3'd1, 8'd2);
        wr(3'd0, 8'h30); wr(3'd0, 8'h30); peek(3'd1, 8'd0);
        wr(3'd0, 8'h30); peek(3'd1, 8'd0); peek(3'd0, 8'h16);
        wr(3'd0, 8'h40); peek(3'd1, 8'd0); peek(3'd0, 8'h06);
        wr(3'd0, 8'h20); peek(3'd0, 8'h06);
        wr(3'd1, 8'd76); wr(3'd0, 8'h50);
        peek(3'd1, 8'd76); peek(3'd0, 8'h12);

        // R8 and R7: head load, hold and timeout
        cur_req = "R8";
        wr(3'd0, 8'h08);
        peek(3'd0, 8'h26);
        idle(20); peek(3'd0, 8'h26);
        idle(10); peek(3'd0, 8'h06);
        wr(3'd0, 8'h08); idle(20);
        wr(3'd0, 8'h08); idle(20);
        peek(3'd0, 8'h26);
        idle(12); peek(3'd0, 8'h06);

        // R9 and R7: drive select, not-ready and write-protect bits
        cur_req = "R9";
        wr(3'd4, 8'h10);
        chk("R9", int'(drv_sel), 2);
        cur_req = "R7";
        peek(3'd0, 8'h84);
        cur_req = "R12";
        peek(3'd1, 8'd0); peek(3'd2, 8'd1);
        cur_req = "R9";
        peek(3'd4, 8'h80);
        wr(3'd4, 8'h20);
        cur_req = "R7";
        peek(3'd0, 8'h46);
        cur_req = "R9";
        wr(3'd4, 8'h00); chk("R9", int'(drv_sel), 3);
        peek(3'd0, 8'h06);
        wr(3'd4, 8'h30); chk("R9", int'(drv_sel), 0);

        // R12: independent directions per drive
        cur_req = "R12";
        wr(3'd3, 8'd10); wr(3'd0, 8'h10); wr(3'd0, 8'h70);
        wr(3'd4, 8'h00); wr(3'd0, 8'h50);
        wr(3'd4, 8'h30); wr(3'd0, 8'h30);
        peek(3'd1, 8'd8);
        wr(3'd4, 8'h00); peek(3'd1, 8'd1);
        wr(3'd4, 8'h30);

        // R10: data command hand-off
        cur_req = "R10";
        wr(3'd0, 8'h88);
        chk("R10", int'(xfer_start), 1); chk("R10", int'(xfer_abort), 1); chk("R10", int'(xfer_cmd), 8);
        peek(3'd0, 8'h23);
        chk("R10", int'(xfer_start), 0);
        peek(3'd4, 8'h80);
        cyc(1'b0, 3'd4, 8'd0, 1'b1);
        chk("R10", int'(bus_rdata), 8'h00);
        peek(3'd0, 8'h22);
        wr(3'd3, 8'd96); wr(3'd0, 8'h10);
        peek(3'd0, 8'h32);
        wr(3'd0, 8'hC0);
        peek(3'd0, 8'h23); peek(3'd4, 8'h80);
        cyc(1'b0, 3'd0, 8'd0, 1'b1);
        wr(3'd0, 8'hE0);
        wr(3'd4, 8'h00);
        cyc(1'b0, 3'd0, 8'd0, 1'b1);
        wr(3'd4, 8'h30);
        peek(3'd4, 8'h00);

        // R11: force interrupt
        cur_req = "R11";
        wr(3'd0, 8'hA0);
        wr(3'd0, 8'hD0);
        chk("R11", int'(xfer_abort), 1); chk("R11", int'(xfer_start), 0);
        peek(3'd4, 8'h80);
        cyc(1'b0, 3'd0, 8'd0, 1'b0);
        chk("R11", int'(bus_rdata[0]), 0);
        wr(3'd0, 8'hD0);
        peek(3'd4, 8'h80);

        // R2 again: mid-run reset restores defaults, direction inward
        cur_req = "R2";
        rst_n = 1'b0;
        idle(1);
        rst_n = 1'b1;
        peek(3'd1, 8'd0); peek(3'd2, 8'd1); peek(3'd4, 8'h80);
        chk("R2", int'(drv_sel), 0);
        wr(3'd0, 8'h30); peek(3'd1, 8'd1);
        idle(2);
        summary();
    end
endmodule